// File: doc/BRIEF.md
# LNB Supply Mode and Tone Controller

This block turns a small set of configuration bits and one external select pin into the control codes for a satellite LNB supply: a level code for the output regulator, a level code for the boost converter that feeds it, a choice between the transmit and receive output ports, and a gated 22 kHz square-wave tone made by dividing the system clock. Two operating modes exist. In tone mode the select pin keys the tone on and off, and the high-level bit picks the voltage for both rails. In control-word mode the select pin picks the output voltage directly, and the high-level bit instead parks the boost rail at its top value so that fast output steps stay clean.

A cable-drop compensation bit lifts every level by one step. A power-enable bit and an over-temperature flag each force the whole block into a safe state with all codes off, both ports off and the tone silent. The select pin is asynchronous and passes through a synchroniser; the tone divider is held cleared while the tone is gated off, so each burst begins with a full high half-period.

Top module: `lnb_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with power disabled, out_lvl and boost_lvl are 0 (off), tx_on, rx_on and tone_out are 0.
- R2: Level codes are 0 off, 1 low, 2 low+1 V, 3 high, 4 high+1 V (output 13.25/14.25/19.5/20.5 V, boost 15.45/16.45/21.7/22.7 V). In tone mode (word_mode=0) with power active, out_lvl and boost_lvl both equal 1 + 2*hi_sel + drop_comp.
- R3: In tone mode the synchronised sel_pin gates the tone: pin high makes tone_out toggle, pin low holds tone_out at 0; the pin does not change out_lvl or boost_lvl in this mode.
- R4: In control-word mode (word_mode=1) with hi_sel=0, out_lvl and boost_lvl both equal 1 + 2*sel_pin + drop_comp.
- R5: In control-word mode with hi_sel=1, out_lvl equals 1 + 2*sel_pin + drop_comp while boost_lvl is forced to 3 + drop_comp; boost_lvl is never below out_lvl.
- R6: drop_comp=1 raises every non-off output and boost code by exactly one step relative to drop_comp=0.
- R7: With power active, tx_sel=1 gives tx_on=1, rx_on=0, and tx_sel=0 gives tx_on=0, rx_on=1; the two are never both 1.
- R8: pwr_en=0 forces out_lvl=0, boost_lvl=0, tx_on=0, rx_on=0 and tone_out=0 whatever the other inputs are.
- R9: hot_flag=1 forces the same off state as pwr_en=0 while it is asserted.
- R10: While gated on, tone_out stays high for exactly CLK_HZ/(2*TONE_HZ) clock cycles and low for the same count (50 % duty).
- R11: After sel_pin rises in tone mode, tone_out goes high SYNC_STAGES+1 clock edges later, starting with a full high half-period.
- R12: In control-word mode tone_out stays 0 whatever sel_pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that the tone divider counts |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable bit; 0 turns everything off |
| hot_flag | input | 1 | Over-temperature flag; 1 turns everything off |
| word_mode | input | 1 | 0 tone mode, 1 control-word mode |
| hi_sel | input | 1 | Tone mode: high/low level; word mode: park boost rail high |
| drop_comp | input | 1 | Cable-drop compensation, adds one level step |
| tx_sel | input | 1 | 1 selects the transmit port, 0 the receive port |
| sel_pin | input | 1 | Asynchronous select pin (tone gate or level select) |
| out_lvl | output | 3 | Output regulator level code |
| boost_lvl | output | 3 | Boost converter level code |
| tx_on | output | 1 | Transmit output port enable |
| rx_on | output | 1 | Receive output port enable |
| tone_out | output | 1 | Gated 22 kHz square wave |

## Verification
The bench builds the block with CLK_HZ set to 440000 and TONE_HZ to 22000, which makes each tone half-period ten clock cycles, so burst start latency, exact high and low run lengths and gating off can all be measured over several periods in a few hundred cycles. SYNC_STAGES stays at 2 and OUT_REG at 1, so the select pin and the level codes each carry a known, small latency that the bench waits out before comparing. Every combination of mode, high-level bit, compensation and pin that changes a code is driven, together with the two shutdown inputs during an active burst.

// File: rtl/lnb_mode_pkg.sv
package lnb_mode_pkg;

   typedef logic [2:0] lvl_t;

   localparam lvl_t LVL_OFF = 3'd0;

   typedef struct packed {
      logic pwr_en;
      logic hot_flag;
      logic word_mode;
      logic hi_sel;
      logic drop_comp;
      logic tx_sel;
   } cfg_t;

   typedef struct packed {
      lvl_t out_lvl;
      lvl_t boost_lvl;
      logic tx_on;
      logic rx_on;
   } ctl_t;

   // 1 = low, 2 = low+step, 3 = high, 4 = high+step
   function automatic lvl_t lvl_code(input logic hi, input logic step);
      lvl_t base;
      base = hi ? 3'd3 : 3'd1;
      return base + {2'b00, step};
   endfunction

endpackage

// File: rtl/lnb_pin_sync.sv
module lnb_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/lnb_mode_dec.sv
module lnb_mode_dec
   import lnb_mode_pkg::*;
(
   input  cfg_t cfg,
   input  logic pin_s,
   output ctl_t ctl,
   output logic tone_gate
);

   logic active;

   assign active = cfg.pwr_en & ~cfg.hot_flag;

   always_comb begin
      ctl = '0;
      if (active) begin
         ctl.tx_on = cfg.tx_sel;
         ctl.rx_on = ~cfg.tx_sel;
         if (!cfg.word_mode) begin
            ctl.out_lvl   = lvl_code(cfg.hi_sel, cfg.drop_comp);
            ctl.boost_lvl = lvl_code(cfg.hi_sel, cfg.drop_comp);
         end else begin
            ctl.out_lvl = lvl_code(pin_s, cfg.drop_comp);
            if (cfg.hi_sel) ctl.boost_lvl = lvl_code(1'b1, cfg.drop_comp);
            else            ctl.boost_lvl = lvl_code(pin_s, cfg.drop_comp);
         end
      end
   end

   assign tone_gate = active & ~cfg.word_mode & pin_s;

endmodule

// File: rtl/lnb_tone_div.sv
module lnb_tone_div #(
   parameter int HALF = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   output logic tone
);

   localparam int CNT_W = (HALF > 2) ? $clog2(HALF) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

   logic [CNT_W-1:0] cnt;
   logic             started;
   logic             tone_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         started <= 1'b0;
         tone_q  <= 1'b0;
      end else if (!gate) begin
         cnt     <= '0;
         started <= 1'b0;
         tone_q  <= 1'b0;
      end else if (!started) begin
         cnt     <= '0;
         started <= 1'b1;
         tone_q  <= 1'b1;
      end else if (cnt == LAST) begin
         cnt    <= '0;
         tone_q <= ~tone_q;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign tone = tone_q;

endmodule

// File: rtl/lnb_mode_ctrl.sv
module lnb_mode_ctrl
   import lnb_mode_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int TONE_HZ     = 22_000,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_en,
   input  logic       hot_flag,
   input  logic       word_mode,
   input  logic       hi_sel,
   input  logic       drop_comp,
   input  logic       tx_sel,
   input  logic       sel_pin,
   output logic [2:0] out_lvl,
   output logic [2:0] boost_lvl,
   output logic       tx_on,
   output logic       rx_on,
   output logic       tone_out
);

   localparam int HALF_DIV = (TONE_HZ > 0) ? CLK_HZ / (2 * TONE_HZ) : 0;

   generate
      if (TONE_HZ <= 0) begin : g_bad_tone
         $error("lnb_mode_ctrl: TONE_HZ must be positive");
      end
      if (HALF_DIV < 2) begin : g_bad_div
         $error("lnb_mode_ctrl: CLK_HZ too low for TONE_HZ");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("lnb_mode_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   cfg_t cfg;
   ctl_t ctl_d;
   ctl_t ctl_q;
   logic pin_s;
   logic tone_gate;

   assign cfg = '{pwr_en:    pwr_en,
                  hot_flag:  hot_flag,
                  word_mode: word_mode,
                  hi_sel:    hi_sel,
                  drop_comp: drop_comp,
                  tx_sel:    tx_sel};

   lnb_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sel_pin),
      .q     (pin_s)
   );

   lnb_mode_dec u_dec (
      .cfg       (cfg),
      .pin_s     (pin_s),
      .ctl       (ctl_d),
      .tone_gate (tone_gate)
   );

   lnb_tone_div #(.HALF(HALF_DIV)) u_tone (
      .clk   (clk),
      .rst_n (rst_n),
      .gate  (tone_gate),
      .tone  (tone_out)
   );

   generate
      if (OUT_REG) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ctl_q <= '0;
            else        ctl_q <= ctl_d;
         end
      end else begin : g_comb_out
         assign ctl_q = ctl_d;
      end
   endgenerate

   assign out_lvl   = ctl_q.out_lvl;
   assign boost_lvl = ctl_q.boost_lvl;
   assign tx_on     = ctl_q.tx_on;
   assign rx_on     = ctl_q.rx_on;

endmodule

// File: rtl/lnb_mode_chk.sv
module lnb_mode_chk #(
   parameter int HALF = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_en,
   input logic       hot_flag,
   input logic       word_mode,
   input logic [2:0] out_lvl,
   input logic [2:0] boost_lvl,
   input logic       tx_on,
   input logic       rx_on,
   input logic       tone_out
);

   localparam int RUN_W = $clog2(HALF + 2) + 1;

   logic [RUN_W-1:0] run_hi;
   logic             live;

   assign live = pwr_en & ~hot_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run_hi <= '0;
      else if (!tone_out)            run_hi <= '0;
      else if (run_hi < RUN_W'(HALF + 1)) run_hi <= run_hi + 1'b1;
   end

   p_off_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !$past(live)) |->
         (out_lvl == 3'd0 && boost_lvl == 3'd0 && !tx_on && !rx_on && !tone_out));

   p_hot_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_flag && $past(hot_flag)) |-> (out_lvl == 3'd0 && !tone_out));

   p_port_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_on && rx_on));

   p_boost_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      boost_lvl >= out_lvl);

   p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_lvl <= 3'd4) && (boost_lvl <= 3'd4));

   p_word_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
      word_mode |=> !tone_out);

   p_half_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tone_out |-> (run_hi < RUN_W'(HALF)));

endmodule

bind lnb_mode_ctrl lnb_mode_chk #(.HALF(HALF_DIV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pwr_en    (pwr_en),
   .hot_flag  (hot_flag),
   .word_mode (word_mode),
   .out_lvl   (out_lvl),
   .boost_lvl (boost_lvl),
   .tx_on     (tx_on),
   .rx_on     (rx_on),
   .tone_out  (tone_out)
);

// File: tb/sim_lnb_mode_ctrl.sv
module sim_lnb_mode_ctrl;

   localparam int CLK_HZ  = 440_000;
   localparam int TONE_HZ = 22_000;
   localparam int SYNC    = 2;
   localparam int HALF    = CLK_HZ / (2 * TONE_HZ);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_en = 1'b0, hot_flag = 1'b0, word_mode = 1'b0;
   logic       hi_sel = 1'b0, drop_comp = 1'b0, tx_sel = 1'b0, sel_pin = 1'b0;
   logic [2:0] out_lvl, boost_lvl;
   logic       tx_on, rx_on, tone_out;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [2:0] o;
      logic [2:0] b;
      logic       tx;
      logic       rx;
      logic       tn;
      bit         use_tn;
      string      tag;
   } exp_t;

   exp_t exp_q[$];

   always #10 clk = ~clk;

   lnb_mode_ctrl #(
      .CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .SYNC_STAGES(SYNC), .OUT_REG(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .hot_flag(hot_flag),
      .word_mode(word_mode), .hi_sel(hi_sel), .drop_comp(drop_comp),
      .tx_sel(tx_sel), .sel_pin(sel_pin), .out_lvl(out_lvl),
      .boost_lvl(boost_lvl), .tx_on(tx_on), .rx_on(rx_on), .tone_out(tone_out)
   );

   function automatic logic [2:0] code(input logic hi, input logic c);
      return 3'(1 + 2 * int'(hi) + int'(c));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: compares outputs with queued expectations
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(out_lvl === e.o,   {e.tag, " out_lvl"},   int'(out_lvl),   int'(e.o));
         chk(boost_lvl === e.b, {e.tag, " boost_lvl"}, int'(boost_lvl), int'(e.b));
         chk(tx_on === e.tx,    {e.tag, " tx_on"},     int'(tx_on),     int'(e.tx));
         chk(rx_on === e.rx,    {e.tag, " rx_on"},     int'(rx_on),     int'(e.rx));
         if (e.use_tn)
            chk(tone_out === e.tn, {e.tag, " tone_out"}, int'(tone_out), int'(e.tn));
      end
   end

   // driver: applies a configuration, waits out the latency, queues the expectation
   task automatic drive(input logic en, hot, wm, hi, cp, tx, pin,
                        input logic [2:0] eo, eb, input logic etx, erx, etn,
                        input bit use_tn, input string tag);
      exp_t e;
      @(negedge clk);
      pwr_en = en; hot_flag = hot; word_mode = wm; hi_sel = hi;
      drop_comp = cp; tx_sel = tx; sel_pin = pin;
      repeat (SYNC + 3) @(posedge clk);
      e.o = eo; e.b = eb; e.tx = etx; e.rx = erx; e.tn = etn;
      e.use_tn = use_tn; e.tag = tag;
      exp_q.push_back(e);
      wait (exp_q.size() == 0);
   endtask

   task automatic run_len(input logic lvl, output int n);
      n = 0;
      while (tone_out === lvl && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #(200_000 * 20);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
   end

   initial begin
      int d;
      int n;
      bit quiet;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_lvl == 0 && boost_lvl == 0, "R1 codes in reset", int'(out_lvl), 0);
      chk(!tx_on && !rx_on && !tone_out, "R1 ports/tone in reset",
          int'({tx_on, rx_on, tone_out}), 0);
      rst_n = 1'b1;
      drive(0,0,0,0,0,0,0, 0,0,0,0,0, 1, "R1 after release");

      // R2 / R6: tone mode level table
      for (int k = 0; k < 4; k++) begin
         logic h = k[1];
         logic c = k[0];
         drive(1,0,0,h,c,0,0, code(h,c), code(h,c), 0,1,0, 1, "R2 R6 tone mode levels");
      end
      // R3: pin high in tone mode leaves levels untouched
      drive(1,0,0,1,0,0,1, 3'd3, 3'd3, 0,1,0, 0, "R3 pin ignored for levels");
      drive(1,0,0,0,1,1,1, 3'd2, 3'd2, 1,0,0, 0, "R3 R7 pin ignored, tx port");

      // R4: word mode, boost follows pin
      for (int k = 0; k < 4; k++) begin
         logic p = k[1];
         logic c = k[0];
         drive(1,0,1,0,c,0,p, code(p,c), code(p,c), 0,1,0, 1, "R4 word mode follow");
      end
      // R5 / R6: word mode, boost parked high
      for (int k = 0; k < 4; k++) begin
         logic p = k[1];
         logic c = k[0];
         drive(1,0,1,1,c,1,p, code(p,c), code(1'b1,c), 1,0,0, 1, "R5 R6 word mode boost parked");
      end

      // R7: port select
      drive(1,0,0,0,0,1,0, 3'd1, 3'd1, 1,0,0, 1, "R7 tx selected");
      drive(1,0,0,0,0,0,0, 3'd1, 3'd1, 0,1,0, 1, "R7 rx selected");

      // R8 / R9: shutdown
      drive(0,0,1,1,1,1,1, 0,0,0,0,0, 1, "R8 power disabled");
      drive(1,1,0,1,1,1,1, 0,0,0,0,0, 1, "R9 hot flag");
      drive(1,0,0,1,1,1,0, 3'd4, 3'd4, 1,0,0, 1, "R9 recovery after hot");

      // R10 / R11: tone burst timing
      @(negedge clk);
      sel_pin = 1'b1;
      d = 0;
      @(negedge clk);
      while (tone_out !== 1'b1 && d < 50) begin
         d++;
         @(negedge clk);
      end
      chk(d == SYNC, "R11 tone start latency", d, SYNC);
      run_len(1'b1, n);
      chk(n == HALF, "R10 R11 first high half", n, HALF);
      run_len(1'b0, n);
      chk(n == HALF, "R10 low half", n, HALF);
      run_len(1'b1, n);
      chk(n == HALF, "R10 second high half", n, HALF);
      run_len(1'b0, n);
      chk(n == HALF, "R10 second low half", n, HALF);

      // R3: pin low stops the tone
      sel_pin = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      quiet = 1;
      for (int i = 0; i < 3 * HALF; i++) begin
         if (tone_out !== 1'b0) quiet = 0;
         @(negedge clk);
      end
      chk(quiet, "R3 tone gated off", int'(!quiet), 0);

      // R8 during a burst
      sel_pin = 1'b1;
      repeat (SYNC + HALF / 2) @(negedge clk);
      chk(tone_out === 1'b1, "R3 tone burst running", int'(tone_out), 1);
      drive(0,0,0,1,1,1,1, 0,0,0,0,0, 1, "R8 disable mid-burst");
      // R9 during a burst
      drive(1,0,0,1,1,1,1, 3'd4, 3'd4, 1,0,0, 0, "R3 burst restored");
      drive(1,1,0,1,1,1,1, 0,0,0,0,0, 1, "R9 hot mid-burst");

      // R12: word mode, pin toggling produces no tone
      drive(1,0,1,0,0,0,1, 3'd3, 3'd3, 0,1,0, 1, "R12 word mode pin high");
      quiet = 1;
      for (int i = 0; i < 4 * HALF; i++) begin
         @(negedge clk);
         sel_pin = (i % 7) < 3;
         if (tone_out !== 1'b0) quiet = 0;
      end
      chk(quiet, "R12 no tone in word mode", int'(!quiet), 0);

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule